// File: doc/BRIEF.md
# IQ DC Offset Remover

This streaming stage takes signed complex baseband samples, one I and one Q value per valid strobe. It removes the slowly varying DC component from each channel. Each channel keeps its own single-pole low-pass estimate of its mean in a fixed-point accumulator. The integer part of that estimate is subtracted from the incoming sample, and the difference is clipped to the signed sample range. The result appears one clock later with its own valid flag. The block applies no back-pressure.

Software controls the stage through a small register port. It sets the tracking bandwidth as a right-shift amount and reads back both current DC estimates. A `hold` input freezes both estimates, and correction continues with the frozen values. A `clearEst` strobe zeroes both estimates.

Top module: `dcOffsetRemover`

## Requirements
- R1: `outValid` is high in exactly the cycle after the cycle in which `inValid` is sampled high; with `inValid` low, `outValid` stays low. There is no back-pressure.
- R2: For each channel, the output is the input sample minus the integer part (floor) of that channel's accumulator, taken before this sample's update. The accumulator carries 16 fractional bits. I and Q use separate accumulators.
- R3: On each valid cycle without hold, each accumulator becomes acc + ((x·2^16 − acc) >>> k), using an arithmetic shift. Cycles without valid leave both accumulators unchanged.
- R4: When the difference falls outside the signed DATA_W range, the output saturates to the largest or smallest signed value and does not wrap.
- R5: Register address 0, bits [3:0], holds the shift k, with reset value 4. A write of 0 is stored as 1. A larger k makes tracking slower: from a zero estimate, one sample of 1000 at k=4 gives an estimate of 62.
- R6: While `hold` is high, both accumulators keep their values on valid cycles. Outputs are still corrected with the frozen estimates.
- R7: Reads return the shift at address 0 (zero-extended), the I estimate's integer part at address 1 and the Q estimate's integer part at address 2 (both sign-extended two's complement), and zero at address 3. The read path is combinational.
- R8: A cycle with `clearEst` high sets both accumulators to zero, which overrides any update in that cycle. Reset also zeroes them.
- R9: After reset, `outValid`, `outI` and `outQ` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Input sample strobe |
| inI | input | DATA_W | Signed in-phase sample |
| inQ | input | DATA_W | Signed quadrature sample |
| hold | input | 1 | Freeze both DC estimates |
| clearEst | input | 1 | Zero both DC estimates |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address for read and write |
| regWrData | input | DATA_W | Register write data |
| regRdData | output | DATA_W | Register read data (combinational) |
| outValid | output | 1 | Output sample strobe |
| outI | output | DATA_W | Corrected in-phase sample |
| outQ | output | DATA_W | Corrected quadrature sample |

## Verification
A constant step of +1000 on I and −1000 on Q at k=1 follows the estimate's halving approach sample by sample. The mirror image on the two channels separates floor rounding from truncation toward zero, and shows whether the channels are crossed. Holding mid-convergence and then feeding a zero input shows that the estimate froze while correction still used it. Full-scale inputs of opposite sign to a large estimate drive both saturation limits. Single samples at different shifts, together with idle cycles carrying changing data, distinguish the bandwidth setting from gating by the valid strobe.

// File: rtl/dcOffsetPkg.sv
package dcOffsetPkg;
  localparam int SHIFT_W = 4;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_SHIFT = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_EST_I = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_EST_Q = 2'd2;

  typedef struct packed {
    logic               sample;
    logic               update;
    logic               clear;
    logic [SHIFT_W-1:0] shift;
  } dcCtl_t;
endpackage

// File: rtl/dcChannel.sv
module dcChannel
  import dcOffsetPkg::*;
#(
  parameter int DATA_W = 16,
  parameter int FRAC_W = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  dcCtl_t                   ctl,
  input  logic signed [DATA_W-1:0] xIn,
  output logic signed [DATA_W-1:0] yOut,
  output logic signed [DATA_W-1:0] est
);
  localparam int ACC_W = DATA_W + FRAC_W;
  localparam int DIFF_W = ACC_W + 1;
  localparam logic signed [DATA_W-1:0] MAX_V = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic signed [DATA_W-1:0] MIN_V = {1'b1, {(DATA_W-1){1'b0}}};

  logic signed [ACC_W-1:0]  acc;
  logic signed [ACC_W-1:0]  accNext;
  logic signed [DIFF_W-1:0] xWide;
  logic signed [DIFF_W-1:0] diff;
  logic signed [DIFF_W-1:0] step;
  logic signed [DATA_W:0]   corr;
  logic signed [DATA_W-1:0] corrSat;

  always_comb begin
    xWide   = {xIn[DATA_W-1], xIn, {FRAC_W{1'b0}}};
    diff    = xWide - {acc[ACC_W-1], acc};
    step    = diff >>> ctl.shift;
    accNext = acc + step[ACC_W-1:0];
    est     = acc[ACC_W-1:FRAC_W];
    corr    = {xIn[DATA_W-1], xIn} - {est[DATA_W-1], est};
    if (corr[DATA_W] != corr[DATA_W-1])
      corrSat = corr[DATA_W] ? MIN_V : MAX_V;
    else
      corrSat = corr[DATA_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc  <= '0;
      yOut <= '0;
    end else begin
      if (ctl.clear)       acc <= '0;
      else if (ctl.update) acc <= accNext;
      if (ctl.sample)      yOut <= corrSat;
    end
  end

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
    ctl.clear |=> (acc == '0)); // R8
  AST_ACC_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (!ctl.update && !ctl.clear) |=> $stable(acc)); // R6
  AST_SAT_POS: assert property (@(posedge clk) disable iff (rst)
    (ctl.sample && !xIn[DATA_W-1] && est[DATA_W-1]) |=> !yOut[DATA_W-1]); // R4
  AST_SAT_NEG: assert property (@(posedge clk) disable iff (rst)
    (ctl.sample && xIn[DATA_W-1] && !est[DATA_W-1]) |=> yOut[DATA_W-1]); // R4
endmodule

// File: rtl/dcDatapath.sv
module dcDatapath
  import dcOffsetPkg::*;
#(
  parameter int DATA_W = 16,
  parameter int FRAC_W = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  dcCtl_t                   ctl,
  input  logic signed [DATA_W-1:0] inI,
  input  logic signed [DATA_W-1:0] inQ,
  output logic                     outValid,
  output logic signed [DATA_W-1:0] outI,
  output logic signed [DATA_W-1:0] outQ,
  output logic signed [DATA_W-1:0] estI,
  output logic signed [DATA_W-1:0] estQ
);
  localparam int NUM_CH = 2;

  logic signed [DATA_W-1:0] xArr [NUM_CH];
  logic signed [DATA_W-1:0] yArr [NUM_CH];
  logic signed [DATA_W-1:0] eArr [NUM_CH];

  assign xArr[0] = inI;
  assign xArr[1] = inQ;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : gChan
    dcChannel #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) uChan (
      .clk  (clk),
      .rst  (rst),
      .ctl  (ctl),
      .xIn  (xArr[ch]),
      .yOut (yArr[ch]),
      .est  (eArr[ch])
    );
  end

  assign outI = yArr[0];
  assign outQ = yArr[1];
  assign estI = eArr[0];
  assign estQ = eArr[1];

  always_ff @(posedge clk) begin
    if (rst) outValid <= 1'b0;
    else     outValid <= ctl.sample;
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    ctl.sample |=> outValid); // R1
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (rst)
    !ctl.sample |=> !outValid); // R1
endmodule

// File: rtl/dcControl.sv
module dcControl
  import dcOffsetPkg::*;
#(
  parameter int DATA_W = 16,
  parameter int SHIFT_RST = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     inValid,
  input  logic                     hold,
  input  logic                     clearEst,
  input  logic                     regWrEn,
  input  logic [ADDR_W-1:0]        regAddr,
  input  logic [DATA_W-1:0]        regWrData,
  input  logic signed [DATA_W-1:0] estI,
  input  logic signed [DATA_W-1:0] estQ,
  output logic [DATA_W-1:0]        regRdData,
  output dcCtl_t                   ctl
);
  logic [SHIFT_W-1:0] shiftK;
  logic [SHIFT_W-1:0] wrShift;

  assign wrShift = regWrData[SHIFT_W-1:0];

  always_ff @(posedge clk) begin
    if (rst)
      shiftK <= SHIFT_W'(SHIFT_RST);
    else if (regWrEn && regAddr == ADDR_SHIFT)
      shiftK <= (wrShift == '0) ? SHIFT_W'(1) : wrShift;
  end

  always_comb begin
    ctl.sample = inValid;
    ctl.update = inValid && !hold;
    ctl.clear  = clearEst;
    ctl.shift  = shiftK;
  end

  always_comb begin
    unique case (regAddr)
      ADDR_SHIFT: regRdData = DATA_W'(shiftK);
      ADDR_EST_I: regRdData = estI;
      ADDR_EST_Q: regRdData = estQ;
      default:    regRdData = '0;
    endcase
  end

  AST_SHIFT_NONZERO: assert property (@(posedge clk) disable iff (rst)
    shiftK != '0); // R5
  AST_HOLD_NO_UPDATE: assert property (@(posedge clk) disable iff (rst)
    hold |-> !ctl.update); // R6
endmodule

// File: rtl/dcOffsetRemover.sv
module dcOffsetRemover
  import dcOffsetPkg::*;
#(
  parameter int DATA_W = 16,
  parameter int FRAC_W = 16,
  parameter int SHIFT_RST = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     inValid,
  input  logic signed [DATA_W-1:0] inI,
  input  logic signed [DATA_W-1:0] inQ,
  input  logic                     hold,
  input  logic                     clearEst,
  input  logic                     regWrEn,
  input  logic [1:0]               regAddr,
  input  logic [DATA_W-1:0]        regWrData,
  output logic [DATA_W-1:0]        regRdData,
  output logic                     outValid,
  output logic signed [DATA_W-1:0] outI,
  output logic signed [DATA_W-1:0] outQ
);
  dcCtl_t ctl;
  logic signed [DATA_W-1:0] estI;
  logic signed [DATA_W-1:0] estQ;

  dcControl #(.DATA_W(DATA_W), .SHIFT_RST(SHIFT_RST)) uCtl (
    .clk       (clk),
    .rst       (rst),
    .inValid   (inValid),
    .hold      (hold),
    .clearEst  (clearEst),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .estI      (estI),
    .estQ      (estQ),
    .regRdData (regRdData),
    .ctl       (ctl)
  );

  dcDatapath #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) uDp (
    .clk      (clk),
    .rst      (rst),
    .ctl      (ctl),
    .inI      (inI),
    .inQ      (inQ),
    .outValid (outValid),
    .outI     (outI),
    .outQ     (outQ),
    .estI     (estI),
    .estQ     (estQ)
  );
endmodule

// File: tb/tb_dcOffsetRemover.sv
module tb_dcOffsetRemover;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int NV = 8;
  // step response at k=1, then two held samples
  localparam int VI   [NV] = '{1000, 1000, 1000, 1000, 1000, 1000, 1000, 0};
  localparam int VQ   [NV] = '{-1000, -1000, -1000, -1000, -1000, -1000, -1000, 0};
  localparam int VH   [NV] = '{0, 0, 0, 0, 0, 0, 1, 1};
  localparam int EXPI [NV] = '{1000, 500, 250, 125, 63, 32, 16, -984};
  localparam int EXPQ [NV] = '{-1000, -500, -250, -125, -62, -31, -15, 985};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 1'b0;
  logic signed [DW-1:0] inI = '0;
  logic signed [DW-1:0] inQ = '0;
  logic hold = 1'b0;
  logic clearEst = 1'b0;
  logic regWrEn = 1'b0;
  logic [1:0] regAddr = '0;
  logic [DW-1:0] regWrData = '0;
  logic [DW-1:0] regRdData;
  logic outValid;
  logic signed [DW-1:0] outI;
  logic signed [DW-1:0] outQ;

  int nChecks = 0;
  int nFails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dcOffsetRemover dut (
    .clk(clk), .rst(rst), .inValid(inValid), .inI(inI), .inQ(inQ),
    .hold(hold), .clearEst(clearEst), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .outValid(outValid),
    .outI(outI), .outQ(outQ)
  );

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic sendSample(input int i, input int q, input logic h,
                            input int expI, input int expQ, input string tag);
    @(negedge clk);
    inValid = 1'b1; inI = DW'(i); inQ = DW'(q); hold = h;
    @(negedge clk);
    inValid = 1'b0; hold = 1'b0;
    check({tag, " R1 valid"}, int'(outValid), 1);
    check({tag, " I"}, int'(outI), expI);
    check({tag, " Q"}, int'(outQ), expQ);
  endtask

  task automatic writeReg(input logic [1:0] a, input int d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = DW'(d);
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic readCheck(input logic [1:0] a, input int exp, input logic sgn,
                           input string tag);
    regAddr = a;
    #1;
    if (sgn) check(tag, int'($signed(regRdData)), exp);
    else     check(tag, int'(regRdData), exp);
  endtask

  task automatic pulseClear();
    @(negedge clk);
    clearEst = 1'b1;
    @(negedge clk);
    clearEst = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    check("R9 outValid", int'(outValid), 0);
    check("R9 outI", int'(outI), 0);
    check("R9 outQ", int'(outQ), 0);
    readCheck(2'd0, 4, 1'b0, "R5 shift reset value");
    readCheck(2'd1, 0, 1'b1, "R8 estI after reset");
    readCheck(2'd3, 0, 1'b0, "R7 unused address");

    // R5 write of zero stored as one
    writeReg(2'd0, 0);
    readCheck(2'd0, 1, 1'b0, "R5 zero write");

    // R2 R3 R6 table walk at k=1
    pulseClear();
    for (int n = 0; n < NV; n++)
      sendSample(VI[n], VQ[n], VH[n] != 0, EXPI[n], EXPQ[n],
                 $sformatf("R2/R3/R6 vec%0d", n));
    @(negedge clk);
    check("R1 valid drops", int'(outValid), 0);
    readCheck(2'd1, 984, 1'b1, "R7 R6 estI held");
    readCheck(2'd2, -985, 1'b1, "R7 R6 estQ held");

    // R3 idle cycles with changing data do not update
    @(negedge clk);
    inI = 16'sd5000; inQ = -16'sd5000;
    @(negedge clk);
    check("R1 idle no valid", int'(outValid), 0);
    inI = -16'sd7000;
    @(negedge clk);
    readCheck(2'd1, 984, 1'b1, "R3 estI unchanged when idle");
    readCheck(2'd2, -985, 1'b1, "R3 estQ unchanged when idle");

    // R8 clear
    pulseClear();
    readCheck(2'd1, 0, 1'b1, "R8 estI cleared");
    readCheck(2'd2, 0, 1'b1, "R8 estQ cleared");

    // R5 narrower bandwidth with k=4
    writeReg(2'd0, 4);
    sendSample(1000, -1000, 1'b0, 1000, -1000, "R5 k4");
    readCheck(2'd1, 62, 1'b1, "R5 estI k4");
    readCheck(2'd2, -63, 1'b1, "R5 estQ k4");

    // R4 saturation both directions
    pulseClear();
    writeReg(2'd0, 1);
    sendSample(-32768, 32767, 1'b0, -32768, 32767, "R4 prime");
    sendSample(32767, -32768, 1'b0, 32767, -32768, "R4 sat");

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule